// File: doc/BRIEF.md
# Bus Byte Parity Generator and Checker

This unit sits between a bridge core and an internal system bus that carries a 36-bit address and a 128-bit data path with one byte-write enable per data byte. It has two independent streams. On the generate stream, requests from the bridge pick up even per-byte parity on their way onto the bus. Write requests get both address parity and data parity. Read requests get address parity only. A poison input marks a write beat whose data was already known to be bad on the far side. For such a beat every data parity bit is inverted, so any bus agent sees the data as corrupted.

On the check stream, beats arriving from the bus have their parity recomputed and compared. Outbound write traffic is checked on both address and data. Read completions are checked on data only. Each accepted beat is forwarded with registered per-lane error vectors and a poison flag, which lets the far side send the data on with bad parity. A sticky error bit gathers every mismatch until software pulses a clear.

Both streams use valid/ready handshakes, and each has a single output register. A beat is taken when valid and ready are both high. An input's ready is high when its output register is empty or when the output's ready is high in that same cycle. While an output's valid is high and its ready is low, the output holds every field unchanged.

Top module: `bus_parity_unit`

## Requirements
- R1: Data parity bit i (i = 0..15) is the XOR of data bits [8i+7:8i] with byte-enable bit i. This is even parity: a byte of all zeros with its enable low gives 0.
- R2: Address parity has 5 bits. Bit k (k = 0..3) is the XOR of address bits [8k+7:8k], and bit 4 is the XOR of address bits [35:32].
- R3: An accepted write request (gen_is_write=1) leaves the unit with its address, data and enables unchanged, together with R2 address parity and R1 data parity. An accepted read request leaves with R2 address parity, and its data, enables and data parity are all zero.
- R4: When gen_poison=1 on a write request, all 16 data parity bits are inverted relative to R1. Address parity is unaffected.
- R5: On the check stream, the data error vector bit i is 1 exactly when the received data parity bit i differs from R1. The address error vector bit k is 1 exactly when chk_has_addr=1 and the received address parity bit k differs from R2. When chk_has_addr=0 (read completion), the address error vector is zero.
- R6: The error vectors, data and enables of an accepted check beat appear on the fwd outputs in the cycle after acceptance, with fwd_valid high. fwd_poison is 1 exactly when the beat has at least one data lane error.
- R7: err_sticky is set by any accepted check beat that has an address or data error. It stays set until err_clear is high in a cycle with no new error. A clear and a new error in the same cycle leave it set.
- R8: A check beat presented with chk_valid low is ignored. It changes neither err_sticky nor fwd_valid.
- R9: While out_valid=1 and out_ready=0, gen_ready is 0 and all out_* fields hold. When out_ready returns, the held beat leaves and a waiting beat is taken in the same cycle. The check stream follows the same rule with fwd_ready and chk_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_valid | input | 1 | Request beat from the bridge is valid |
| gen_ready | output | 1 | Generate stream can take a beat |
| gen_is_write | input | 1 | 1 = write request, 0 = read request |
| gen_poison | input | 1 | Write data is known bad; invert data parity |
| gen_addr | input | 36 | Request address |
| gen_data | input | 128 | Write data |
| gen_be | input | 16 | Byte-write enables |
| out_valid | output | 1 | Bus-side request beat valid |
| out_ready | input | 1 | Bus side accepts the request beat |
| out_is_write | output | 1 | Registered write flag |
| out_addr | output | 36 | Registered address |
| out_apar | output | 5 | Generated address parity |
| out_data | output | 128 | Registered data (zero for reads) |
| out_be | output | 16 | Registered enables (zero for reads) |
| out_dpar | output | 16 | Generated data parity (zero for reads) |
| chk_valid | input | 1 | Beat from the bus is valid |
| chk_ready | output | 1 | Check stream can take a beat |
| chk_has_addr | input | 1 | 1 = write traffic with address phase, 0 = read completion |
| chk_addr | input | 36 | Received address |
| chk_apar | input | 5 | Received address parity |
| chk_data | input | 128 | Received data |
| chk_be | input | 16 | Received enables |
| chk_dpar | input | 16 | Received data parity |
| fwd_valid | output | 1 | Checked beat valid toward the far side |
| fwd_ready | input | 1 | Far side accepts the checked beat |
| fwd_data | output | 128 | Checked data |
| fwd_be | output | 16 | Checked enables |
| fwd_poison | output | 1 | Beat carried a data parity error |
| fwd_derr | output | 16 | Per-lane data error vector |
| fwd_aerr | output | 5 | Per-lane address error vector |
| err_clear | input | 1 | Pulse to clear err_sticky |
| err_sticky | output | 1 | Sticky error status |

## Verification
The generate stream is swept with walking ones over all 128 data bits, all 16 enables and all 36 address bits. Each of these single-bit patterns moves exactly one parity lane, so a swapped lane, a missing enable term or a wrongly bounded top address group shows up at once. Dense pseudo-random words, read requests and poisoned writes then separate correct even-parity folding from mistakes in polarity, read masking and inversion. The check stream is driven with clean beats and with single flipped data, parity and address-parity bits, under both transaction kinds. This shows per-lane attribution, poison derivation and address masking on completions. Back-pressure, invalid beats and clear-versus-error collisions cover the handshake and sticky rules.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  function automatic int lane_count(input int width, input int lane_w);
    return (width + lane_w - 1) / lane_w;
  endfunction
endpackage

// File: rtl/bpu_lane_par.sv
module bpu_lane_par #(
  parameter int WIDTH  = 36,
  parameter int LANE_W = 8,
  parameter int NL     = bpu_pkg::lane_count(WIDTH, LANE_W)
) (
  input  logic [WIDTH-1:0] vec,
  input  logic [NL-1:0]    extra,
  output logic [NL-1:0]    par
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int LO = i * LANE_W;
    localparam int HI = (LO + LANE_W > WIDTH) ? WIDTH - 1 : LO + LANE_W - 1;
    assign par[i] = (^vec[HI:LO]) ^ extra[i];
  end
endmodule

// File: rtl/bpu_gen_stage.sv
module bpu_gen_stage #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  parameter int NA     = bpu_pkg::lane_count(ADDR_W, LANE_W),
  parameter int ND     = bpu_pkg::lane_count(DATA_W, LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_write,
  input  logic              in_poison,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ND-1:0]     in_be,
  output logic              o_valid,
  input  logic              o_ready,
  output logic              o_is_write,
  output logic [ADDR_W-1:0] o_addr,
  output logic [NA-1:0]     o_apar,
  output logic [DATA_W-1:0] o_data,
  output logic [ND-1:0]     o_be,
  output logic [ND-1:0]     o_dpar
);
  logic [NA-1:0] apar_c;
  logic [ND-1:0] dpar_c;
  logic          take;

  bpu_lane_par #(.WIDTH(ADDR_W), .LANE_W(LANE_W)) u_apar (
    .vec(in_addr), .extra('0), .par(apar_c));
  bpu_lane_par #(.WIDTH(DATA_W), .LANE_W(LANE_W)) u_dpar (
    .vec(in_data), .extra(in_be), .par(dpar_c));

  assign in_ready = !o_valid || o_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid    <= 1'b0;
      o_is_write <= 1'b0;
      o_addr     <= '0;
      o_apar     <= '0;
      o_data     <= '0;
      o_be       <= '0;
      o_dpar     <= '0;
    end else if (take) begin
      o_valid    <= 1'b1;
      o_is_write <= in_is_write;
      o_addr     <= in_addr;
      o_apar     <= apar_c;
      o_data     <= in_is_write ? in_data : '0;
      o_be       <= in_is_write ? in_be : '0;
      o_dpar     <= in_is_write ? (dpar_c ^ {ND{in_poison}}) : '0;
    end else if (o_ready) begin
      o_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/bpu_chk_stage.sv
module bpu_chk_stage #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  parameter int NA     = bpu_pkg::lane_count(ADDR_W, LANE_W),
  parameter int ND     = bpu_pkg::lane_count(DATA_W, LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_has_addr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NA-1:0]     in_apar,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ND-1:0]     in_be,
  input  logic [ND-1:0]     in_dpar,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DATA_W-1:0] o_data,
  output logic [ND-1:0]     o_be,
  output logic              o_poison,
  output logic [ND-1:0]     o_derr,
  output logic [NA-1:0]     o_aerr,
  input  logic              clr,
  output logic              sticky
);
  logic [NA-1:0] apar_c, aerr_n;
  logic [ND-1:0] dpar_c, derr_n;
  logic          take, any_err;

  bpu_lane_par #(.WIDTH(ADDR_W), .LANE_W(LANE_W)) u_apar (
    .vec(in_addr), .extra('0), .par(apar_c));
  bpu_lane_par #(.WIDTH(DATA_W), .LANE_W(LANE_W)) u_dpar (
    .vec(in_data), .extra(in_be), .par(dpar_c));

  assign in_ready = !o_valid || o_ready;
  assign take     = in_valid && in_ready;
  assign derr_n   = dpar_c ^ in_dpar;
  assign aerr_n   = (apar_c ^ in_apar) & {NA{in_has_addr}};
  assign any_err  = take && ((|derr_n) || (|aerr_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_data   <= '0;
      o_be     <= '0;
      o_poison <= 1'b0;
      o_derr   <= '0;
      o_aerr   <= '0;
    end else if (take) begin
      o_valid  <= 1'b1;
      o_data   <= in_data;
      o_be     <= in_be;
      o_poison <= |derr_n;
      o_derr   <= derr_n;
      o_aerr   <= aerr_n;
    end else if (o_ready) begin
      o_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= 1'b0;
    else        sticky <= (sticky && !clr) || any_err;
  end
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  parameter int NA     = bpu_pkg::lane_count(ADDR_W, LANE_W),
  parameter int ND     = bpu_pkg::lane_count(DATA_W, LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_valid,
  output logic              gen_ready,
  input  logic              gen_is_write,
  input  logic              gen_poison,
  input  logic [ADDR_W-1:0] gen_addr,
  input  logic [DATA_W-1:0] gen_data,
  input  logic [ND-1:0]     gen_be,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_write,
  output logic [ADDR_W-1:0] out_addr,
  output logic [NA-1:0]     out_apar,
  output logic [DATA_W-1:0] out_data,
  output logic [ND-1:0]     out_be,
  output logic [ND-1:0]     out_dpar,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic              chk_has_addr,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [NA-1:0]     chk_apar,
  input  logic [DATA_W-1:0] chk_data,
  input  logic [ND-1:0]     chk_be,
  input  logic [ND-1:0]     chk_dpar,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [DATA_W-1:0] fwd_data,
  output logic [ND-1:0]     fwd_be,
  output logic              fwd_poison,
  output logic [ND-1:0]     fwd_derr,
  output logic [NA-1:0]     fwd_aerr,
  input  logic              err_clear,
  output logic              err_sticky
);
  bpu_gen_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .in_valid(gen_valid), .in_ready(gen_ready), .in_is_write(gen_is_write),
    .in_poison(gen_poison), .in_addr(gen_addr), .in_data(gen_data), .in_be(gen_be),
    .o_valid(out_valid), .o_ready(out_ready), .o_is_write(out_is_write),
    .o_addr(out_addr), .o_apar(out_apar), .o_data(out_data), .o_be(out_be),
    .o_dpar(out_dpar));

  bpu_chk_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(chk_valid), .in_ready(chk_ready), .in_has_addr(chk_has_addr),
    .in_addr(chk_addr), .in_apar(chk_apar), .in_data(chk_data), .in_be(chk_be),
    .in_dpar(chk_dpar),
    .o_valid(fwd_valid), .o_ready(fwd_ready), .o_data(fwd_data), .o_be(fwd_be),
    .o_poison(fwd_poison), .o_derr(fwd_derr), .o_aerr(fwd_aerr),
    .clr(err_clear), .sticky(err_sticky));
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int NA = 5,
  parameter int ND = 16,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_valid,
  input logic              gen_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_write,
  input logic [DATA_W-1:0] out_data,
  input logic [ND-1:0]     out_be,
  input logic [ND-1:0]     out_dpar,
  input logic              chk_valid,
  input logic              chk_ready,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ND-1:0]     fwd_derr,
  input logic [NA-1:0]     fwd_aerr,
  input logic              err_sticky
);
  // R9: held request beat stays put
  a_r9_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dpar));

  // R9: no acceptance while output is stalled
  a_r9_gen_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !gen_ready);

  // R9: held checked beat stays put
  a_r9_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_derr) && $stable(fwd_aerr));

  // R3: read requests carry no data, enables or data parity
  a_r3_read_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_write |-> out_dpar == '0 && out_be == '0 && out_data == '0);

  // R6: an accepted check beat shows up the next cycle
  a_r6_fwd_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_ready |=> fwd_valid);

  // R7: an error on a freshly accepted beat is reflected in the sticky bit
  a_r7_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_ready |=> ((fwd_derr != '0) || (fwd_aerr != '0)) -> err_sticky);
endmodule

bind bus_parity_unit bpu_checker #(.NA(NA), .ND(ND), .DATA_W(DATA_W)) u_bpu_checker (
  .clk(clk), .rst_n(rst_n),
  .gen_valid(gen_valid), .gen_ready(gen_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_is_write(out_is_write),
  .out_data(out_data), .out_be(out_be), .out_dpar(out_dpar),
  .chk_valid(chk_valid), .chk_ready(chk_ready),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
  .fwd_derr(fwd_derr), .fwd_aerr(fwd_aerr), .err_sticky(err_sticky));

// File: tb/bus_parity_unit_tb.sv
module bus_parity_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic gen_valid = 0, gen_is_write = 0, gen_poison = 0;
  logic [35:0] gen_addr = '0;
  logic [127:0] gen_data = '0;
  logic [15:0] gen_be = '0;
  logic gen_ready, out_valid, out_is_write;
  logic out_ready = 1;
  logic [35:0] out_addr;
  logic [4:0] out_apar;
  logic [127:0] out_data;
  logic [15:0] out_be, out_dpar;
  logic chk_valid = 0, chk_has_addr = 0;
  logic [35:0] chk_addr = '0;
  logic [4:0] chk_apar = '0;
  logic [127:0] chk_data = '0;
  logic [15:0] chk_be = '0, chk_dpar = '0;
  logic chk_ready, fwd_valid, fwd_poison, err_sticky;
  logic fwd_ready = 1, err_clear = 0;
  logic [127:0] fwd_data;
  logic [15:0] fwd_be, fwd_derr;
  logic [4:0] fwd_aerr;

  int total = 0, bad = 0;
  bit done = 0;

  bus_parity_unit u_dut (.*);

  function automatic logic [15:0] ref_dpar(input logic [127:0] d, input logic [15:0] be);
    logic [15:0] p = be;
    for (int b = 0; b < 128; b++) p[b/8] = p[b/8] ^ d[b];
    return p;
  endfunction

  function automatic logic [4:0] ref_apar(input logic [35:0] a);
    logic [4:0] p = '0;
    for (int b = 0; b < 36; b++) p[b/8] = p[b/8] ^ a[b];
    return p;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gen_beat(input logic wr, input logic poison, input logic [35:0] a,
                          input logic [127:0] d, input logic [15:0] be);
    @(negedge clk);
    gen_valid = 1; gen_is_write = wr; gen_poison = poison;
    gen_addr = a; gen_data = d; gen_be = be;
    @(negedge clk);
    gen_valid = 0;
  endtask

  task automatic gen_test(input string req, input logic wr, input logic poison,
                          input logic [35:0] a, input logic [127:0] d, input logic [15:0] be);
    logic [15:0] ed;
    gen_beat(wr, poison, a, d, be);
    ed = wr ? (ref_dpar(d, be) ^ {16{poison}}) : 16'h0;
    check({req, " apar"}, {123'b0, out_apar}, {123'b0, ref_apar(a)});
    check({req, " dpar"}, {112'b0, out_dpar}, {112'b0, ed});
    check({req, " data"}, out_data, wr ? d : 128'h0);
  endtask

  task automatic chk_beat(input logic has_a, input logic [35:0] a, input logic [4:0] ap,
                          input logic [127:0] d, input logic [15:0] be, input logic [15:0] dp,
                          input logic clr);
    @(negedge clk);
    chk_valid = 1; chk_has_addr = has_a; chk_addr = a; chk_apar = ap;
    chk_data = d; chk_be = be; chk_dpar = dp; err_clear = clr;
    @(negedge clk);
    chk_valid = 0; err_clear = 0;
  endtask

  task automatic chk_test(input string req, input logic has_a, input logic [35:0] a,
                          input logic [4:0] aflip, input logic [127:0] d,
                          input logic [15:0] be, input logic [15:0] dflip);
    chk_beat(has_a, a, ref_apar(a) ^ aflip, d, be, ref_dpar(d, be) ^ dflip, 1'b0);
    check({req, " fwd_valid"}, {127'b0, fwd_valid}, 128'd1);
    check({req, " derr"}, {112'b0, fwd_derr}, {112'b0, dflip});
    check({req, " aerr"}, {123'b0, fwd_aerr}, {123'b0, has_a ? aflip : 5'b0});
    check({req, " poison"}, {127'b0, fwd_poison}, {127'b0, dflip != 0});
    check({req, " data"}, fwd_data, d);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear = 1;
    @(negedge clk); err_clear = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] rd;
    logic [35:0] ra;
    logic [15:0] rb;
    repeat (3) @(negedge clk);
    check("reset out_valid", {127'b0, out_valid}, 128'd0);
    check("reset fwd_valid", {127'b0, fwd_valid}, 128'd0);
    check("reset err_sticky", {127'b0, err_sticky}, 128'd0);
    rst_n = 1;

    // R8: invalid beat with bad parity is ignored
    @(negedge clk);
    chk_valid = 0; chk_has_addr = 1; chk_dpar = 16'hFFFF; chk_apar = 5'h1F;
    @(negedge clk);
    check("R8 sticky", {127'b0, err_sticky}, 128'd0);
    check("R8 fwd_valid", {127'b0, fwd_valid}, 128'd0);

    // R1: walking data bit and enable bit
    for (int b = 0; b < 128; b++) gen_test("R1 data bit", 1, 0, 36'h0, 128'd1 << b, 16'h0);
    for (int b = 0; b < 16; b++) gen_test("R1 enable bit", 1, 0, 36'h0, 128'h0, 16'd1 << b);
    // R2: walking address bit, incl. top 4-bit group
    for (int b = 0; b < 36; b++) gen_test("R2 addr bit", 0, 0, 36'd1 << b, 128'h0, 16'h0);
    // R3 / R4: dense patterns for write, read, poisoned write
    for (int k = 0; k < 24; k++) begin
      rd = {$urandom, $urandom, $urandom, $urandom};
      ra = {$urandom, $urandom};
      rb = 16'($urandom);
      gen_test("R3 write", 1, 0, ra, rd, rb);
      gen_test("R3 read", 0, 0, ra, rd, rb);
      gen_test("R4 poison", 1, 1, ra, rd, rb);
    end

    // R5 / R6: check stream
    for (int k = 0; k < 8; k++) begin
      rd = {$urandom, $urandom, $urandom, $urandom};
      ra = {$urandom, $urandom};
      chk_test("R5 clean write", 1, ra, 5'h0, rd, 16'($urandom), 16'h0);
      chk_test("R5 clean completion", 0, ra, 5'h0, rd, 16'($urandom), 16'h0);
    end
    check("R7 sticky stays clear", {127'b0, err_sticky}, 128'd0);
    for (int i = 0; i < 16; i++)
      chk_test("R6 data lane error", 0, 36'h123456789, 5'h0, 128'hA5 << (8 * i), 16'hF0F0, 16'd1 << i);
    for (int k = 0; k < 5; k++) begin
      chk_test("R5 addr lane write", 1, 36'hFEDCBA987, 5'd1 << k, 128'h0, 16'h0, 16'h0);
      chk_test("R5 addr lane completion", 0, 36'hFEDCBA987, 5'd1 << k, 128'h0, 16'h0, 16'h0);
    end

    // R7: sticky behaviour
    check("R7 sticky set", {127'b0, err_sticky}, 128'd1);
    pulse_clear();
    check("R7 sticky cleared", {127'b0, err_sticky}, 128'd0);
    chk_beat(0, 36'h0, 5'h0, 128'h1, 16'h0, 16'h0, 1'b1);
    check("R7 clear with error", {127'b0, err_sticky}, 128'd1);
    pulse_clear();
    check("R7 cleared again", {127'b0, err_sticky}, 128'd0);

    // R9: back-pressure on generate stream
    out_ready = 0;
    gen_beat(1, 0, 36'h1, 128'h1111, 16'h1);
    @(negedge clk);
    gen_valid = 1; gen_is_write = 1; gen_addr = 36'h2; gen_data = 128'h2222; gen_be = 16'h2;
    #1;
    check("R9 gen_ready low", {127'b0, gen_ready}, 128'd0);
    @(negedge clk);
    check("R9 held data", out_data, 128'h1111);
    out_ready = 1;
    @(negedge clk);
    gen_valid = 0;
    check("R9 next beat", out_data, 128'h2222);
    check("R9 next dpar", {112'b0, out_dpar}, {112'b0, ref_dpar(128'h2222, 16'h2)});

    // R9: back-pressure on check stream
    fwd_ready = 0;
    chk_beat(0, 36'h0, 5'h0, 128'h33, 16'h0, ref_dpar(128'h33, 16'h0), 1'b0);
    @(negedge clk);
    check("R9 chk_ready low", {127'b0, chk_ready}, 128'd0);
    check("R9 fwd held", fwd_data, 128'h33);
    fwd_ready = 1;
    @(negedge clk);
    check("R9 fwd drained", {127'b0, fwd_valid}, 128'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule